// File: doc/BRIEF.md
# Up/down and center-aligned timer counter

This block is the counting core of a general-purpose timer. A parameterised counter (16 bits by default) runs every clock while enabled. It can count up or down in edge-aligned fashion, or it can sweep from zero up to the reload limit and back in one of three center-aligned variants. The variants differ only in which slope may raise the compare interrupt. A single compare channel raises a one-cycle interrupt pulse when the counter meets the compare value. An update pulse marks each wrap or turning point and, depending on configuration, software- or externally requested updates.

Software programs the block through a simple write port with three targets: control, reload limit and compare value. The control word carries a one-pulse option, which drops the enable at the next update event. It also carries an update-source option, which keeps software and external update requests from raising the interrupt, and an option that stages reload writes in a shadow register until the next update event. A separate strobe forces an update event and re-initialises the counter.

Top module: `updn_timer16`

## Requirements
- R1: After reset the control word is all zero (disabled, edge-aligned, counting up, one-pulse off, all update sources raise the interrupt, reload staging off), the counter is 0, the reload limit is all ones, the compare value is 0, and `dir_o`, `upd_irq` and `cmp_irq` are 0.
- R2: A write with `wr_sel`=0 loads the control word: bit 0 enable, bit 1 one-pulse, bit 2 update-source restriction, bit 3 direction, bits 5:4 alignment mode, bit 6 reload staging. `wr_sel`=1 writes the reload limit and `wr_sel`=2 writes the compare value. In mode 00 with the direction bit at 0, the enabled counter steps up by one each clock and wraps from the reload limit (or anything above it) to 0. With the direction bit at 1 it steps down and wraps from 0 to the reload limit. A disabled counter holds its value.
- R3: In modes 01, 10 and 11 the enabled counter starts upward, turns at the reload limit to limit-1 and at 0 to 1, and `dir_o` is 1 exactly while it is on the downward slope. In mode 00, `dir_o` equals the direction bit.
- R4: `cmp_irq` is high for one cycle after a clock in which the enabled counter equalled the compare value, provided the slope allows it: always in modes 00 and 11, only while counting down in mode 01, and only while counting up in mode 10.
- R5: `upd_irq` is high for one cycle in the cycle that shows the wrapped or turned counter value.
- R6: With the update-source bit at 0, a pulse on `ug` or `ext_ur` also raises `upd_irq` in the next cycle. With the bit at 1, those pulses leave `upd_irq` low.
- R7: With the one-pulse bit set, any update event (wrap, turn, `ug` or `ext_ur`) clears the enable, so the counter stops on the value it reached. A control write in the same cycle takes precedence.
- R8: With reload staging off, a reload write takes effect at once. With it on, the write only fills the shadow copy, and the working limit takes the shadow value at the next update event.
- R9: A `ug` pulse copies the shadow into the working limit and reloads the counter: to the shadow value in mode 00 with the direction bit at 1, otherwise to 0. A center-aligned counter then restarts upward.
- R10: A control write made while the counter is enabled in mode 00 keeps mode 00 even if it asks for a center-aligned mode. Its other fields still take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 reload limit, 2 compare value |
| wr_data | input | W | Write data |
| ug | input | 1 | Software update-generate strobe |
| ext_ur | input | 1 | External update-request strobe |
| cnt | output | W | Counter value |
| dir_o | output | 1 | Current slope, 1 = counting down |
| upd_irq | output | 1 | Update interrupt pulse |
| cmp_irq | output | 1 | Compare interrupt pulse |

## Verification
The properties take it for granted that `wr_sel` never carries the unused code 3 and that `ug` and `ext_ur` are plain strobes free of unknowns. The counting properties also exclude cycles where `ug` coincides, since the re-initialisation overrides the step. The directed stimulus and the random phase use only the three valid write targets. The random phase still lets strobes, control writes and wraps land in the same clock on purpose, so that the precedence between write, one-pulse stop and update event is exercised against the reference model.

// File: rtl/updn_timer16_pkg.sv
package updn_timer16_pkg;

    typedef enum logic [1:0] {
        CM_EDGE     = 2'b00,
        CM_CTR_DN   = 2'b01,
        CM_CTR_UP   = 2'b10,
        CM_CTR_BOTH = 2'b11
    } cmode_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_UP   = 2'b01,
        ST_DOWN = 2'b10
    } slope_t;

    localparam logic [1:0] SEL_CTRL   = 2'd0;
    localparam logic [1:0] SEL_RELOAD = 2'd1;
    localparam logic [1:0] SEL_CMP    = 2'd2;

    localparam int B_EN    = 0;
    localparam int B_OPM   = 1;
    localparam int B_URS   = 2;
    localparam int B_DIR   = 3;
    localparam int B_MODE  = 4;
    localparam int B_STAGE = 6;

endpackage

// File: rtl/tmr_cfg_regs.sv
module tmr_cfg_regs
    import updn_timer16_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   wr_sel,
    input  logic [W-1:0] wr_data,
    input  logic         upd_ev,
    output logic         en,
    output logic         opm,
    output logic         urs,
    output logic         dir_bit,
    output cmode_t       mode,
    output logic [W-1:0] arr_act,
    output logic [W-1:0] arr_shd,
    output logic [W-1:0] ccr
);

    logic   stage;
    logic   wr_ctrl, wr_rld, wr_cmp;
    cmode_t mode_req;

    always_comb begin
        wr_ctrl  = wr_en && (wr_sel == SEL_CTRL);
        wr_rld   = wr_en && (wr_sel == SEL_RELOAD);
        wr_cmp   = wr_en && (wr_sel == SEL_CMP);
        mode_req = cmode_t'(wr_data[B_MODE+1:B_MODE]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en      <= 1'b0;
            opm     <= 1'b0;
            urs     <= 1'b0;
            dir_bit <= 1'b0;
            mode    <= CM_EDGE;
            stage   <= 1'b0;
        end else if (wr_ctrl) begin
            en      <= wr_data[B_EN];
            opm     <= wr_data[B_OPM];
            urs     <= wr_data[B_URS];
            dir_bit <= wr_data[B_DIR];
            stage   <= wr_data[B_STAGE];
            if (!(en && mode == CM_EDGE && mode_req != CM_EDGE))
                mode <= mode_req;
        end else if (opm && upd_ev) begin
            en <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arr_shd <= {W{1'b1}};
            arr_act <= {W{1'b1}};
            ccr     <= '0;
        end else begin
            if (wr_rld)
                arr_shd <= wr_data;
            if (wr_rld && !stage)
                arr_act <= wr_data;
            else if (upd_ev)
                arr_act <= arr_shd;
            if (wr_cmp)
                ccr <= wr_data;
        end
    end

endmodule

// File: rtl/tmr_slope_fsm.sv
module tmr_slope_fsm
    import updn_timer16_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         dir_bit,
    input  cmode_t       mode,
    input  logic         urs,
    input  logic [W-1:0] arr_act,
    input  logic [W-1:0] arr_shd,
    input  logic         ug,
    input  logic         ext_ur,
    output logic [W-1:0] cnt,
    output logic         slope_dn,
    output logic         upd_ev,
    output logic         upd_irq
);

    localparam logic [W-1:0] ONE = W'(1);

    slope_t       st_q, st_d, run_next;
    logic [W-1:0] cnt_q, cnt_d;
    logic         wrap, center;

    always_comb begin
        center   = (mode != CM_EDGE);
        slope_dn = center ? (st_q == ST_DOWN) : dir_bit;
        cnt_d    = cnt_q;
        wrap     = 1'b0;
        if (en) begin
            if (!slope_dn) begin
                if (cnt_q >= arr_act) begin
                    wrap  = 1'b1;
                    cnt_d = center ? ((arr_act == '0) ? '0 : arr_act - ONE) : '0;
                end else begin
                    cnt_d = cnt_q + ONE;
                end
            end else begin
                if (cnt_q == '0) begin
                    wrap  = 1'b1;
                    cnt_d = center ? ((arr_act == '0) ? '0 : ONE) : arr_act;
                end else begin
                    cnt_d = cnt_q - ONE;
                end
            end
        end
        if (center)
            run_next = (wrap ^ slope_dn) ? ST_DOWN : ST_UP;
        else
            run_next = dir_bit ? ST_DOWN : ST_UP;

        unique case (st_q)
            ST_IDLE: st_d = en ? run_next : ST_IDLE;
            ST_UP:   st_d = en ? run_next : ST_IDLE;
            ST_DOWN: st_d = en ? run_next : ST_IDLE;
            default: st_d = ST_IDLE;
        endcase

        if (ug) begin
            cnt_d = (!center && dir_bit) ? arr_shd : '0;
            st_d  = !en ? ST_IDLE : ((!center && dir_bit) ? ST_DOWN : ST_UP);
        end
        upd_ev = wrap || ug || ext_ur;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            cnt_q   <= '0;
            upd_irq <= 1'b0;
        end else begin
            st_q    <= st_d;
            cnt_q   <= cnt_d;
            upd_irq <= wrap || (!urs && (ug || ext_ur));
        end
    end

    always_comb cnt = cnt_q;

endmodule

// File: rtl/tmr_cmp_gate.sv
module tmr_cmp_gate
    import updn_timer16_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  cmode_t       mode,
    input  logic         slope_dn,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] ccr,
    output logic         cmp_irq
);

    logic slope_ok;

    always_comb begin
        unique case (mode)
            CM_EDGE:     slope_ok = 1'b1;
            CM_CTR_DN:   slope_ok = slope_dn;
            CM_CTR_UP:   slope_ok = !slope_dn;
            CM_CTR_BOTH: slope_ok = 1'b1;
            default:     slope_ok = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cmp_irq <= 1'b0;
        else        cmp_irq <= en && slope_ok && (cnt == ccr);
    end

endmodule

// File: rtl/updn_timer16.sv
module updn_timer16
    import updn_timer16_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   wr_sel,
    input  logic [W-1:0] wr_data,
    input  logic         ug,
    input  logic         ext_ur,
    output logic [W-1:0] cnt,
    output logic         dir_o,
    output logic         upd_irq,
    output logic         cmp_irq
);

    logic         en, opm, urs, dir_bit, upd_ev, slope_dn;
    cmode_t       mode;
    logic [W-1:0] arr_act, arr_shd, ccr;

    tmr_cfg_regs #(.W(W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .upd_ev(upd_ev), .en(en), .opm(opm),
        .urs(urs), .dir_bit(dir_bit), .mode(mode), .arr_act(arr_act),
        .arr_shd(arr_shd), .ccr(ccr)
    );

    tmr_slope_fsm #(.W(W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .en(en), .dir_bit(dir_bit),
        .mode(mode), .urs(urs), .arr_act(arr_act), .arr_shd(arr_shd),
        .ug(ug), .ext_ur(ext_ur), .cnt(cnt), .slope_dn(slope_dn),
        .upd_ev(upd_ev), .upd_irq(upd_irq)
    );

    tmr_cmp_gate #(.W(W)) u_cmp (
        .clk(clk), .rst_n(rst_n), .en(en), .mode(mode),
        .slope_dn(slope_dn), .cnt(cnt), .ccr(ccr), .cmp_irq(cmp_irq)
    );

    always_comb dir_o = slope_dn;

endmodule

// File: rtl/updn_timer16_chk.sv
module updn_timer16_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         wr_en,
    input logic [1:0]   wr_sel,
    input logic         ug,
    input logic         ext_ur,
    input logic [W-1:0] cnt,
    input logic         dir_o,
    input logic         upd_irq,
    input logic         cmp_irq,
    input logic         en,
    input logic         opm,
    input logic         urs,
    input logic         dir_bit,
    input logic [1:0]   mode,
    input logic [W-1:0] arr_act
);

    p_hold_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !ug) |=> (cnt == $past(cnt)));

    p_edge_up_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && mode == 2'b00 && !dir_bit && !ug && cnt < arr_act)
        |=> (cnt == $past(cnt) + W'(1)));

    p_cmp_down_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_irq && $past(mode) == 2'b01) |-> $past(dir_o));

    p_cmp_up_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_irq && $past(mode) == 2'b10) |-> !$past(dir_o));

    p_quiet_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (urs && !en) |=> !upd_irq);

    p_one_pulse_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && opm && (ug || ext_ur) && !(wr_en && wr_sel == 2'd0)) |=> !en);

    p_mode_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (en && mode == 2'b00) |=> (mode == 2'b00));

endmodule

bind updn_timer16 updn_timer16_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .ug(ug), .ext_ur(ext_ur), .cnt(cnt), .dir_o(dir_o),
    .upd_irq(upd_irq), .cmp_irq(cmp_irq), .en(en), .opm(opm),
    .urs(urs), .dir_bit(dir_bit), .mode(mode), .arr_act(arr_act)
);

// File: tb/sim_updn_timer16.sv
`timescale 1ns/1ps
module sim_updn_timer16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic        ug = 1'b0;
    logic        ext_ur = 1'b0;
    logic [15:0] cnt;
    logic        dir_o, upd_irq, cmp_irq;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    updn_timer16 #(.W(16)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .ug(ug), .ext_ur(ext_ur), .cnt(cnt),
        .dir_o(dir_o), .upd_irq(upd_irq), .cmp_irq(cmp_irq)
    );

    // behavioural reference
    int m_cnt = 0, m_arr = 65535, m_shd = 65535, m_ccr = 0, m_mode = 0;
    bit m_en = 0, m_opm = 0, m_urs = 0, m_dir = 0, m_stage = 0, m_down = 0;
    bit m_uirq = 0, m_cirq = 0;

    always @(posedge clk) begin : model
        int  ncnt, nmode;
        bit  ndown, wrap, down, hit, upd;
        if (!rst_n) begin
            m_cnt = 0; m_arr = 65535; m_shd = 65535; m_ccr = 0; m_mode = 0;
            m_en = 0; m_opm = 0; m_urs = 0; m_dir = 0; m_stage = 0; m_down = 0;
            m_uirq = 0; m_cirq = 0;
        end else begin
            ncnt = m_cnt; ndown = m_down; wrap = 0; hit = 0;
            down = (m_mode == 0) ? m_dir : m_down;
            if (!m_en) ndown = 0;
            else begin
                if (!down) begin
                    if (m_cnt >= m_arr) begin
                        wrap = 1;
                        if (m_mode == 0) ncnt = 0;
                        else begin ncnt = (m_arr == 0) ? 0 : m_arr - 1; ndown = 1; end
                    end else ncnt = m_cnt + 1;
                end else begin
                    if (m_cnt == 0) begin
                        wrap = 1;
                        if (m_mode == 0) ncnt = m_arr;
                        else begin ncnt = (m_arr == 0) ? 0 : 1; ndown = 0; end
                    end else ncnt = m_cnt - 1;
                end
                if (m_mode == 0) ndown = m_dir;
                hit = (m_cnt == m_ccr) && (m_mode == 0 || m_mode == 3 ||
                      (m_mode == 1 && down) || (m_mode == 2 && !down));
            end
            if (ug) begin
                ncnt  = (m_mode == 0 && m_dir) ? m_shd : 0;
                ndown = m_en && m_mode == 0 && m_dir;
            end
            upd    = wrap || ug || ext_ur;
            m_uirq = wrap || (!m_urs && (ug || ext_ur));
            m_cirq = hit;
            if (wr_en && wr_sel == 1) begin
                if (!m_stage) m_arr = wr_data;
                else if (upd) m_arr = m_shd;
                m_shd = wr_data;
            end else if (upd) m_arr = m_shd;
            if (wr_en && wr_sel == 2) m_ccr = wr_data;
            if (wr_en && wr_sel == 0) begin
                nmode = int'(wr_data[5:4]);
                if (!(m_en && m_mode == 0 && nmode != 0)) m_mode = nmode;
                m_en = wr_data[0]; m_opm = wr_data[1]; m_urs = wr_data[2];
                m_dir = wr_data[3]; m_stage = wr_data[6];
            end else if (m_opm && upd) m_en = 0;
            m_cnt = ncnt & 16'hFFFF; m_down = ndown;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(cnt == m_cnt[15:0], "R2 counter value", cnt, m_cnt);
            chk(dir_o == m_down_view(), "R3 slope output", dir_o, m_down_view());
            chk(upd_irq == m_uirq, "R5 update pulse", upd_irq, m_uirq);
            chk(cmp_irq == m_cirq, "R4 compare pulse", cmp_irq, m_cirq);
        end
    end

    function automatic int m_down_view();
        return (m_mode == 0) ? int'(m_dir) : int'(m_down);
    endfunction

    task automatic wr(input logic [1:0] sel, input logic [15:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_ug();
        ug = 1'b1; @(negedge clk); ug = 1'b0;
    endtask

    task automatic pulse_ext();
        ext_ur = 1'b1; @(negedge clk); ext_ur = 1'b0;
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        bit saw_dn;
        int guard;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        chk(cnt == 0, "R1 reset counter", cnt, 0);
        chk(dir_o == 0, "R1 reset slope", dir_o, 0);
        chk(upd_irq == 0 && cmp_irq == 0, "R1 reset pulses", upd_irq | cmp_irq, 0);
        wr(0, 16'h0009);
        @(negedge clk);
        chk(cnt == 16'hFFFF, "R1 reset reload limit", cnt, 65535);
        wr(0, 16'h0000);

        // edge-aligned up and down
        wr(1, 16'd5); wr(2, 16'd3); pulse_ug();
        wr(0, 16'h0001); repeat (20) @(negedge clk);
        wr(0, 16'h0009); repeat (20) @(negedge clk);

        // three center-aligned variants
        for (int m = 1; m < 4; m++) begin
            wr(0, 16'h0000);
            wr(0, 16'((m << 4) | 1));
            repeat (26) @(negedge clk);
        end

        // one-pulse
        wr(0, 16'h0000); pulse_ug(); wr(1, 16'd3);
        wr(0, 16'h0003);
        repeat (8) @(negedge clk);
        chk(cnt == 0, "R7 stopped after overflow", cnt, 0);
        repeat (3) @(negedge clk);
        chk(cnt == 0 && upd_irq == 0, "R7 remains stopped", cnt, 0);

        // update request source
        wr(0, 16'h0004); pulse_ug();
        chk(upd_irq == 0, "R6 software update muted", upd_irq, 0);
        pulse_ext();
        chk(upd_irq == 0, "R6 external update muted", upd_irq, 0);
        wr(0, 16'h0000); pulse_ext();
        chk(upd_irq == 1, "R6 external update raises", upd_irq, 1);

        // update generation reinitialises
        wr(1, 16'd6); wr(0, 16'h0008); pulse_ug();
        chk(cnt == 6, "R9 reload on down ug", cnt, 6);
        wr(0, 16'h0000); pulse_ug();
        chk(cnt == 0, "R9 zero on up ug", cnt, 0);

        // staged reload
        wr(1, 16'd9); pulse_ug(); wr(0, 16'h0041);
        guard = 0;
        while (cnt != 5 && guard < 40) begin @(negedge clk); guard++; end
        wr(1, 16'd2);
        chk(cnt == 6, "R8 staged write not yet active", cnt, 6);
        repeat (4) @(negedge clk);
        chk(cnt == 0, "R8 wrap at old limit", cnt, 0);
        repeat (3) @(negedge clk);
        chk(cnt == 0, "R8 new limit after update", cnt, 0);

        // mode lock while running
        wr(0, 16'h0000); wr(1, 16'd7); pulse_ug(); wr(0, 16'h0001);
        wr(0, 16'h0011);
        saw_dn = 0;
        for (int i = 0; i < 20; i++) begin @(negedge clk); if (dir_o) saw_dn = 1; end
        chk(saw_dn == 0, "R10 center request ignored", saw_dn, 0);
        wr(0, 16'h0000); wr(0, 16'h0011);
        saw_dn = 0;
        for (int i = 0; i < 20; i++) begin @(negedge clk); if (dir_o) saw_dn = 1; end
        chk(saw_dn == 1, "R10 center accepted when stopped", saw_dn, 1);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            wr_en = 1'b0; ug = 1'b0; ext_ur = 1'b0;
            if (r < 4) begin
                wr_en = 1'b1; wr_sel = 2'd0;
                wr_data = 16'($urandom_range(0, 127) | ($urandom_range(0, 3) != 0 ? 1 : 0));
            end else if (r < 8) begin
                wr_en = 1'b1; wr_sel = 2'd1; wr_data = 16'($urandom_range(0, 12));
            end else if (r < 11) begin
                wr_en = 1'b1; wr_sel = 2'd2; wr_data = 16'($urandom_range(0, 12));
            end
            if ($urandom_range(0, 49) == 0) ug = 1'b1;
            if ($urandom_range(0, 49) == 0) ext_ur = 1'b1;
            @(negedge clk);
        end
        wr_en = 1'b0; ug = 1'b0; ext_ur = 1'b0;
        @(negedge clk);
        finish_run();
    end

endmodule